// File: doc/BRIEF.md
# Divide-by-three processor clock generator

This block derives a processor clock and a peripheral clock from a fast timing source. It runs entirely inside one fast system clock domain. Each of the two possible sources, an oscillator and an external frequency input, arrives as a single-cycle strobe, and each strobe marks one source period. A select input picks which source advances a divide-by-three phase counter. The processor clock is high for one of every three selected strobes and low for the other two. A toggle stage that flips on every falling edge of the processor clock produces the peripheral clock at half the processor rate.

A synchronization input lets several copies of the block run in phase. Sampled on selected strobes, it holds the counter at its first phase with the processor clock high and clears the peripheral toggle. After release, every copy steps from the same point. A change of the select input is deferred until the counter wraps, or until a sync strobe, so the processor clock never shows a runt pulse. A pass-through output returns the oscillator strobe one system clock later, whichever source is selected.

Top module: `clkdiv3_gen`

## Requirements
- R1: On the selected source, the processor clock repeats every three strobes: high for one strobe period (phase 0) and low for two (phases 1 and 2).
- R2: With the select input low, only oscillator strobes advance the counter. With it high, only external strobes do. Strobes on the unselected source change no output.
- R3: A selected strobe that arrives with sync high sets the counter to phase 0. The processor clock then reads high and stays high for as long as sync stays high.
- R4: After sync falls, the first selected strobe drives the processor clock low. The third selected strobe drives it high again, so no high pulse is shorter than one strobe period.
- R5: The peripheral clock has twice the processor clock period: high for three selected strobes, then low for three.
- R6: The peripheral clock toggles only at the strobe that drives the processor clock low. A sync strobe clears it to 0.
- R7: The oscillator pass-through output equals the oscillator strobe of the previous system clock cycle, whatever the select setting.
- R8: A new select value takes effect only on a selected strobe at phase 2 (the wrap to phase 0) or on a selected strobe with sync high.
- R9: During and right after reset, the processor clock is 1, the peripheral clock is 0, the pass-through is 0 and the oscillator is the selected source.
- R10: The processor and peripheral clocks change at the system clock edge that samples the selected strobe, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator source strobe, one cycle per source period |
| ext_tick | input | 1 | External frequency source strobe |
| src_sel | input | 1 | Source select: 0 oscillator, 1 external |
| sync_in | input | 1 | Phase synchronization, active high |
| cpu_clk | output | 1 | Processor clock, one third of the source rate, 1/3 high |
| per_clk | output | 1 | Peripheral clock, half the processor rate, 50% duty |
| osc_out | output | 1 | Oscillator strobe passed through one cycle later |

## Verification
Each output is due exactly one system clock edge after the cycle in which its stimulus is applied. For the processor and peripheral clocks, the counter and the toggle flop are the only registers on the path. The pass-through has a single flop. The driver applies each cycle's inputs just after a rising edge and queues the values it expects at the next edge. The monitor holds every queued item for one falling edge and compares it at the falling edge after the design's edge, so each sample lands halfway between the edge that updates the outputs and the next one. Deferred source switches, sync release and ignored strobes all flow through the same per-cycle queue, so none of them needs its own wait or window.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;

  // Phase that follows ph in a counter of length div.
  function automatic int unsigned next_phase(int unsigned ph, int unsigned div);
    return (ph + 1 >= div) ? 0 : ph + 1;
  endfunction

  // The processor clock is high while the phase is below the high count.
  function automatic logic phase_high(int unsigned ph, int unsigned hi);
    return ph < hi;
  endfunction

  // Phase whose exit produces the falling edge of the processor clock.
  function automatic int unsigned fall_phase(int unsigned hi);
    return hi - 1;
  endfunction

endpackage

// File: rtl/clkdiv3_src_mux.sv
module clkdiv3_src_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic ext_tick,
  input  logic sel_req,
  input  logic commit,
  output logic tick,
  output logic sel_q
);

  // The selection in use changes only when the divider says it is safe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= 1'b0;
    else if (commit)
      sel_q <= sel_req;
  end

  assign tick = sel_q ? ext_tick : osc_tick;

  // R8: the applied selection moves only after a commit event
  a_r8_sel_at_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(commit));

endmodule

// File: rtl/clkdiv3_counter.sv
module clkdiv3_counter #(
  parameter int unsigned DIV_RATIO  = 3,
  parameter int unsigned HIGH_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_in,
  output logic cpu_clk,
  output logic sync_ev,
  output logic wrap_ev,
  output logic fall_ev
);
  import clkdiv3_pkg::*;

  localparam int unsigned PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam int unsigned LAST_PH = DIV_RATIO - 1;
  localparam int unsigned FALL_PH = fall_phase(HIGH_TICKS);

  logic [PW-1:0] phase;

  // Named events for the neighbours and for the assertions.
  assign sync_ev = tick && sync_in;
  assign wrap_ev = tick && !sync_in && (32'(phase) == LAST_PH);
  assign fall_ev = tick && !sync_in && (32'(phase) == FALL_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (sync_ev)
      phase <= '0;
    else if (tick)
      phase <= PW'(next_phase(32'(phase), DIV_RATIO));
  end

  assign cpu_clk = phase_high(32'(phase), HIGH_TICKS);

  // R1: the phase never leaves its range
  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(phase) < DIV_RATIO);

  // R3: a sync strobe leaves the counter at phase 0 with the clock high
  a_r3_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev |=> (phase == '0) && cpu_clk);

  // R4: the clock falls only after a strobe taken in the fall phase
  a_r4_fall_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk) |-> $past(fall_ev));

endmodule

// File: rtl/clkdiv3_per_toggle.sv
module clkdiv3_per_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_ev,
  input  logic clr,
  output logic per_clk
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      per_clk <= 1'b0;
    else if (clr)
      per_clk <= 1'b0;
    else if (fall_ev)
      per_clk <= ~per_clk;
  end

endmodule

// File: rtl/clkdiv3_gen.sv
module clkdiv3_gen #(
  parameter int unsigned DIV_RATIO  = 3,
  parameter int unsigned HIGH_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic ext_tick,
  input  logic src_sel,
  input  logic sync_in,
  output logic cpu_clk,
  output logic per_clk,
  output logic osc_out
);

  logic tick;
  logic sel_q;
  logic sync_ev;
  logic wrap_ev;
  logic fall_ev;
  logic commit;

  // A selection change is safe at a wrap or while the counter is forced.
  assign commit = wrap_ev || sync_ev;

  clkdiv3_src_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .ext_tick (ext_tick),
    .sel_req  (src_sel),
    .commit   (commit),
    .tick     (tick),
    .sel_q    (sel_q)
  );

  clkdiv3_counter #(
    .DIV_RATIO  (DIV_RATIO),
    .HIGH_TICKS (HIGH_TICKS)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sync_in (sync_in),
    .cpu_clk (cpu_clk),
    .sync_ev (sync_ev),
    .wrap_ev (wrap_ev),
    .fall_ev (fall_ev)
  );

  clkdiv3_per_toggle u_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall_ev (fall_ev),
    .clr     (sync_ev),
    .per_clk (per_clk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      osc_out <= 1'b0;
    else
      osc_out <= osc_tick;
  end

  // R6: the peripheral clock moves only on a processor clock fall or a sync
  a_r6_per_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (per_clk != $past(per_clk)) |-> ($past(fall_ev) || $past(sync_ev)));

  // R6: a processor clock fall always flips the peripheral clock
  a_r6_fall_flips: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> (per_clk != $past(per_clk)));

endmodule

// File: tb/clkdiv3_gen_tb.sv
module clkdiv3_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic ext_tick = 1'b0;
  logic src_sel = 1'b0;
  logic sync_in = 1'b0;
  logic cpu_clk, per_clk, osc_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic  cpu;
    logic  per;
    logic  osc;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t held;
  bit   pending = 0;

  // Bench model: source in use, position inside the 3-strobe period, toggle.
  int  m_pos = 0;
  bit  m_src = 0;
  bit  m_per = 0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv3_gen u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_tick(ext_tick),
    .src_sel(src_sel), .sync_in(sync_in),
    .cpu_clk(cpu_clk), .per_clk(per_clk), .osc_out(osc_out)
  );

  task automatic check1(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the outputs due after
  // the next rising edge (R10: one edge of latency).
  task automatic drive(bit o, bit e, bit s, bit y);
    exp_t it;
    bit strobe;
    @(posedge clk);
    #1;
    osc_tick = o; ext_tick = e; src_sel = s; sync_in = y;
    strobe = m_src ? e : o;
    if (strobe) begin
      if (y) begin
        m_pos = 0; m_per = 0; m_src = s;
      end else begin
        if (m_pos == 0) m_per = !m_per;
        if (m_pos == 2) m_src = s;
        m_pos = (m_pos == 2) ? 0 : m_pos + 1;
      end
    end
    it.cpu = (m_pos == 0);
    it.per = m_per;
    it.osc = o;
    it.tag = cur_tag;
    sb.push_back(it);
  endtask

  // Monitor: holds an item for one falling edge, compares at the next.
  always @(negedge clk) begin
    if (pending) begin
      check1(held.tag, "cpu_clk", cpu_clk, held.cpu);
      check1(held.tag, "per_clk", per_clk, held.per);
      check1("R7", "osc_out", osc_out, held.osc);
      pending = 0;
    end
    if (sb.size() > 0) begin
      held = sb.pop_front();
      pending = 1;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check1("R9", "cpu_clk", cpu_clk, 1'b1);
    check1("R9", "per_clk", per_clk, 1'b0);
    check1("R9", "osc_out", osc_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R9", "cpu_clk after release", cpu_clk, 1'b1);
    check1("R9", "per_clk after release", per_clk, 1'b0);

    // R3: sync held across several oscillator strobes keeps the clock high
    cur_tag = "R3";
    for (int i = 0; i < 6; i++) drive(1, 0, 0, 1);

    // R4 / R1 / R5 / R6: release, then a strobe every cycle
    cur_tag = "R4";
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0);
    cur_tag = "R5";
    for (int i = 0; i < 18; i++) drive(1, 0, 0, 0);

    // R1: a strobe every other cycle
    cur_tag = "R1";
    for (int i = 0; i < 18; i++) drive(i % 2 == 0, 0, 0, 0);

    // R2: external strobes are ignored while the oscillator is selected
    cur_tag = "R2";
    for (int i = 0; i < 9; i++) drive(0, 1, 0, 0);

    // R8: request the external source mid-period; oscillator rules until wrap
    cur_tag = "R8";
    drive(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(1, 0, 1, 0);
    for (int i = 0; i < 12; i++) drive(1, i % 3 == 0, 1, 0);

    // R2: external source drives the counter, oscillator strobes ignored
    cur_tag = "R2";
    for (int i = 0; i < 12; i++) drive(i % 2 == 0, 1, 1, 0);

    // R6 / R3: sync mid-run on the external source clears the toggle
    cur_tag = "R6";
    for (int i = 0; i < 4; i++) drive(0, 1, 1, 0);
    drive(0, 1, 1, 1);
    drive(0, 0, 1, 1);
    drive(0, 1, 0, 1);       // R8: sync strobe commits the oscillator at once
    cur_tag = "R4";
    for (int i = 0; i < 9; i++) drive(1, 0, 0, 0);

    // R10 / mixed: pseudo-random stimulus through the same model
    cur_tag = "R10";
    for (int i = 0; i < 400; i++)
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 15) == 0));

    drive(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule